// File: doc/BRIEF.md
# Memory-Mapped Terminal Controller

This peripheral connects a processor's word-wide load/store path to a character terminal. It has an input side that takes bytes from a keyboard and an output side that drives characters to a display. Software reaches it through four 32-bit registers at fixed addresses. Each direction has a control word and a data word.

A ready flag in each control word tells software whether it can act:
- On the receiver, the flag means a character is waiting to be read.
- On the transmitter, the flag means the display can take another character.

Each direction also has an interrupt-enable bit. The shared interrupt line is raised while any enabled direction is ready.

The flags are not written directly. They change as a side effect of data-register traffic:
- Reading received data clears the receiver flag.
- Writing transmit data drops the transmitter flag until the character has been delivered.

Delivery completion depends on a parameter:
- In timed mode it happens after a fixed cycle count.
- In handshake mode it happens when the display acknowledges.

Top module: `term_mmio`

## Requirements
- R1: Registers sit at BASE+0x0 (input control), BASE+0x4 (input data), BASE+0x8 (output control) and BASE+0xC (output data), with BASE = 0xFFFF0000 by default. Bus reads return data combinationally in the same cycle as `bus_rd`, and read 0 when `bus_rd` is low. Reading output data, or any other address, returns 0. A write to any other address changes nothing.
- R2: A control read returns the ready flag in bit 0 and the interrupt enable in bit 1. Bits 31:2 read as 0.
- R3: A cycle with `kbd_valid` high stores `kbd_byte` and sets input ready at that edge. An input-data read returns the stored byte in bits 7:0, with bits 31:8 at 0.
- R4: An input-data read clears input ready at that clock edge. If `kbd_valid` is high in the same cycle, the new byte is stored and ready stays 1.
- R5: A byte that arrives while input ready is already 1 replaces the stored byte, and ready stays 1.
- R6: A write to output data while output ready is 1 puts `bus_wdata[7:0]` on `disp_byte` and drops output ready from the next cycle. `disp_valid` is high exactly while output ready is 0.
- R7: With USE_ACK = 0, output ready stays 0 for exactly TX_CYCLES cycles after the accepting edge, and `disp_ack` is ignored.
- R8: With USE_ACK = 1, output ready stays 0 until the edge at which `disp_ack` is sampled high. After that edge it is 1.
- R9: A write to output data while output ready is 0 is discarded. `disp_byte` and the busy period are unchanged.
- R10: A control write loads only the interrupt enable, from `bus_wdata[1]`. Bit 0 of the written value has no effect on the ready flag.
- R11: `irq` is high whenever (input enable AND input ready) OR (output enable AND output ready).
- R12: After reset both enables are 0, input ready is 0, output ready is 1, `disp_byte` is 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| kbd_valid | input | 1 | Keyboard byte present this cycle |
| kbd_byte | input | 8 | Keyboard character |
| disp_valid | output | 1 | Character on `disp_byte` is being delivered |
| disp_byte | output | 8 | Character for the display |
| disp_ack | input | 1 | Display has taken the character (handshake mode) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a bus cycle never raises `bus_rd` and `bus_wr` together. They also assume that addresses are word aligned whenever they are meant to hit a register. The stimulus drives at most one strobe per cycle and draws its addresses from the four registers plus two unmapped words.

The assertions make no assumption about `disp_ack` outside a busy period; the bench drives it only at chosen moments. Keyboard bytes may arrive in any cycle, including the cycle of an input-data read. That case is used on purpose to exercise the priority of a new arrival over the clearing read.

// File: rtl/term_mmio.sv
module term_mmio #(
  parameter logic [31:0] BASE      = 32'hFFFF_0000,
  parameter int          TX_CYCLES = 6,
  parameter bit          USE_ACK   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        kbd_valid,
  input  logic [7:0]  kbd_byte,
  output logic        disp_valid,
  output logic [7:0]  disp_byte,
  input  logic        disp_ack,
  output logic        irq
);
  localparam int CW = (TX_CYCLES > 1) ? $clog2(TX_CYCLES) : 1;

  logic          rx_rdy, rx_ie, tx_rdy, tx_ie;
  logic [7:0]    rx_buf;
  logic [CW-1:0] cnt;

  wire       hit = (bus_addr[31:4] == BASE[31:4]) && (bus_addr[1:0] == 2'b00);
  wire [1:0] idx = bus_addr[3:2];

  wire rd_rxd = bus_rd & hit & (idx == 2'd1);
  wire wr_rxc = bus_wr & hit & (idx == 2'd0);
  wire wr_txc = bus_wr & hit & (idx == 2'd2);
  wire wr_txd = bus_wr & hit & (idx == 2'd3);

  wire tx_done = USE_ACK ? disp_ack : (cnt == '0);

  wire unused_wdata = ^bus_wdata[31:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0;
      rx_buf <= 8'h00;
    end else if (kbd_valid) begin
      rx_rdy <= 1'b1;
      rx_buf <= kbd_byte;
    end else if (rd_rxd) begin
      rx_rdy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else begin
      if (wr_rxc) rx_ie <= bus_wdata[1];
      if (wr_txc) tx_ie <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rdy    <= 1'b1;
      disp_byte <= 8'h00;
      cnt       <= '0;
    end else if (tx_rdy) begin
      if (wr_txd) begin
        tx_rdy    <= 1'b0;
        disp_byte <= bus_wdata[7:0];
        cnt       <= CW'(TX_CYCLES - 1);
      end
    end else if (tx_done) begin
      tx_rdy <= 1'b1;
    end else if (!USE_ACK) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd && hit) begin
      case (idx)
        2'd0:    bus_rdata = {30'h0, rx_ie, rx_rdy};
        2'd1:    bus_rdata = {24'h0, rx_buf};
        2'd2:    bus_rdata = {30'h0, tx_ie, tx_rdy};
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  assign disp_valid = ~tx_rdy;
  assign irq        = (rx_ie & rx_rdy) | (tx_ie & tx_rdy);
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
  parameter logic [31:0] BASE    = 32'hFFFF_0000,
  parameter bit          USE_ACK = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic        kbd_valid,
  input logic [7:0]  kbd_byte,
  input logic [7:0]  disp_byte,
  input logic        disp_ack,
  input logic        rx_rdy,
  input logic        rx_ie,
  input logic        tx_rdy,
  input logic [7:0]  rx_buf
);
  wire is_reg = (bus_addr[31:4] == BASE[31:4]) && (bus_addr[1:0] == 2'b00);

  a_r3_arrival_stored: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |=> (rx_rdy && rx_buf == $past(kbd_byte)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_reg && bus_addr[3:2] == 2'd1 && !kbd_valid) |=> !rx_rdy);

  a_r6_tx_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_reg && bus_addr[3:2] == 2'd3 && tx_rdy)
      |=> (!tx_rdy && disp_byte == $past(bus_wdata[7:0])));

  a_r9_busy_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rdy |=> $stable(disp_byte));

  a_r10_ie_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && is_reg && bus_addr[3:2] == 2'd0) |=> $stable(rx_ie));

  a_r8_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_ACK && !tx_rdy && !disp_ack) |=> !tx_rdy);
endmodule

bind term_mmio term_mmio_chk #(.BASE(BASE), .USE_ACK(USE_ACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .kbd_valid(kbd_valid),
  .kbd_byte(kbd_byte), .disp_byte(disp_byte), .disp_ack(disp_ack),
  .rx_rdy(rx_rdy), .rx_ie(rx_ie), .tx_rdy(tx_rdy), .rx_buf(rx_buf)
);

// File: tb/term_mmio_bench.sv
module term_mmio_bench;
  localparam int N = 6;
  localparam logic [31:0] B = 32'hFFFF_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_rd = 0, bus_wr = 0, kbd_valid = 0, disp_ack = 0;
  logic [7:0] kbd_byte = 0;
  logic [31:0] rdata [2];
  logic dv [2];
  logic [7:0] db [2];
  logic irq [2];
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  term_mmio #(.TX_CYCLES(N), .USE_ACK(1'b0)) u_term_mmio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
    .disp_valid(dv[0]), .disp_byte(db[0]), .disp_ack(disp_ack), .irq(irq[0]));

  term_mmio #(.TX_CYCLES(N), .USE_ACK(1'b1)) u_term_mmio_ack (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
    .disp_valid(dv[1]), .disp_byte(db[1]), .disp_ack(disp_ack), .irq(irq[1]));

  // behavioural reference: flags plus the cycle at which delivery ends
  bit m_rxr[2], m_rxie[2], m_txr[2], m_txie[2];
  int m_rxb[2], m_byte[2], m_done[2];
  int cyc = 0;

  initial for (int i = 0; i < 2; i++) begin
    m_rxr[i] = 0; m_rxie[i] = 0; m_txr[i] = 1; m_txie[i] = 0;
    m_rxb[i] = 0; m_byte[i] = 0; m_done[i] = 0;
  end

  function automatic bit sel(int off);
    return bus_addr == (B + off);
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    if (!bus_rd) return 0;
    if (sel(0)) return {30'h0, m_rxie[i], m_rxr[i]};
    if (sel(4)) return m_rxb[i];
    if (sel(8)) return {30'h0, m_txie[i], m_txr[i]};
    return 0;
  endfunction

  function automatic string rd_tag();
    if (sel(0) || sel(8)) return "R2";
    if (sel(4)) return "R3";
    return "R1";
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    for (int i = 0; i < 2; i++) begin
      bit was_ready, done_now;
      if (!rst_n) begin
        m_rxr[i] = 0; m_rxie[i] = 0; m_txr[i] = 1; m_txie[i] = 0;
        m_rxb[i] = 0; m_byte[i] = 0;
      end else begin
        was_ready = m_txr[i];
        done_now = (i == 1) ? (disp_ack === 1'b1) : (cyc >= m_done[i]);
        if (kbd_valid) begin m_rxb[i] = kbd_byte; m_rxr[i] = 1; end
        else if (bus_rd && sel(4)) m_rxr[i] = 0;
        if (bus_wr && sel(0)) m_rxie[i] = bus_wdata[1];
        if (bus_wr && sel(8)) m_txie[i] = bus_wdata[1];
        if (was_ready && bus_wr && sel(12)) begin
          m_txr[i] = 0; m_byte[i] = bus_wdata[7:0]; m_done[i] = cyc + N;
        end else if (!was_ready && done_now) m_txr[i] = 1;
      end
    end
    #2;
    for (int i = 0; i < 2; i++) begin
      cmp(rd_tag(), rdata[i], exp_rd(i));
      cmp("R6", {31'h0, dv[i]}, {31'h0, !m_txr[i]});
      cmp("R6", {24'h0, db[i]}, m_byte[i]);
      cmp("R11", {31'h0, irq[i]},
          {31'h0, (m_rxie[i] && m_rxr[i]) || (m_txie[i] && m_txr[i])});
    end
  end

  task automatic idle(); @(negedge clk); endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [31:0] a, logic [31:0] e, string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 cmp(tag, rdata[0], e);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic key(logic [7:0] b);
    @(negedge clk); kbd_valid = 1; kbd_byte = b;
    @(negedge clk); kbd_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) idle();
    rst_n = 1;
    // R12 reset state
    rd(B + 0, 32'h0, "R12");
    rd(B + 8, 32'h1, "R12");
    cmp("R12", {31'h0, irq[0]}, 0);
    // R3 arrival and read
    key(8'h41);
    rd(B + 0, 32'h1, "R3");
    rd(B + 4, 32'h41, "R3");
    rd(B + 0, 32'h0, "R4");
    // R5 overwrite while ready
    key(8'h10); key(8'h22);
    rd(B + 0, 32'h1, "R5");
    rd(B + 4, 32'h22, "R5");
    // R4 read colliding with a new arrival
    key(8'h55);
    @(negedge clk); bus_addr = B + 4; bus_rd = 1; kbd_valid = 1; kbd_byte = 8'h33;
    #1 cmp("R4", rdata[0], 32'h55);
    @(negedge clk); bus_rd = 0; kbd_valid = 0;
    rd(B + 0, 32'h1, "R4");
    rd(B + 4, 32'h33, "R4");
    // R10 only enable is written
    wr(B + 0, 32'hFFFF_FFFF);
    rd(B + 0, 32'h2, "R10");
    cmp("R11", {31'h0, irq[0]}, 0);
    key(8'h7E);
    cmp("R11", {31'h0, irq[0]}, 1);
    rd(B + 4, 32'h7E, "R11");
    cmp("R11", {31'h0, irq[0]}, 0);
    wr(B + 0, 32'h1);
    rd(B + 0, 32'h0, "R10");
    // R6, R9, R7, R8 transmit
    wr(B + 12, 32'h1234_565A);
    cmp("R6", {24'h0, db[0]}, 32'h5A);
    cmp("R6", {31'h0, dv[0]}, 1);
    wr(B + 12, 32'h77);
    cmp("R9", {24'h0, db[0]}, 32'h5A);
    repeat (N - 3) idle();
    cmp("R7", {31'h0, dv[0]}, 1);
    idle();
    cmp("R7", {31'h0, dv[0]}, 0);
    rd(B + 8, 32'h1, "R7");
    repeat (4) idle();
    cmp("R8", {31'h0, dv[1]}, 1);
    @(negedge clk); disp_ack = 1;
    @(negedge clk); disp_ack = 0;
    cmp("R8", {31'h0, dv[1]}, 0);
    cmp("R8", {24'h0, db[1]}, 32'h5A);
    // R11 transmit side, R1 unmapped accesses
    wr(B + 8, 32'h2);
    cmp("R11", {31'h0, irq[0]}, 1);
    wr(B + 16, 32'h0);
    wr(32'h0000_0008, 32'h0);
    rd(B + 8, 32'h3, "R1");
    rd(B + 16, 32'h0, "R1");
    rd(B + 12, 32'h0, "R1");
    wr(B + 8, 32'h0);
    // mixed traffic against the reference
    for (int k = 0; k < 400; k++) begin
      int a;
      @(negedge clk);
      a = $urandom_range(0, 5);
      bus_addr = (a < 4) ? B + 4 * a : (a == 4 ? B + 16 : 32'h1000_0000);
      bus_wdata = $urandom;
      bus_rd = 0; bus_wr = 0;
      case ($urandom_range(0, 2))
        0: bus_rd = 1;
        1: bus_wr = 1;
        default: ;
      endcase
      kbd_valid = ($urandom_range(0, 3) == 0);
      kbd_byte = $urandom;
      disp_ack = ($urandom_range(0, 4) == 0);
    end
    @(negedge clk); bus_rd = 0; bus_wr = 0; kbd_valid = 0; disp_ack = 0;
    repeat (3) idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule